// File: doc/BRIEF.md
# Write-Protect and Status-Register Controller

This block sits beside the serial front end of a byte-wide nonvolatile memory. It holds the status byte and decides, for every write the front end decodes, whether that write may go ahead. A write-enable latch is set and cleared by two dedicated command pulses. Two block-protect bits select how much of the array, counted from the top address down, refuses writes. A hardware-protect arming bit makes the write-protect pin guard the status register.

A write that passes its checks when it is requested is held pending while chip select stays low. It is granted on the rising edge of chip select, and the internal write cycle then starts. If the armed protect pin drops while a status write is still pending, that write is cancelled. Once the cycle is running, the pin has no further effect. A write that is refused produces a one-cycle deny pulse and starts no cycle.

Top module: `wpc_top`

## Requirements
- R1: After reset the status byte reads 0x00, and neither grant nor deny is asserted.
- R2: A `cmd_wren` pulse sets the write-enable latch (status bit 1) and a `cmd_wrdi` pulse clears it. When both arrive in the same cycle, the latch is cleared.
- R3: A status or array write request made while the latch is clear is denied (a `wr_deny_o` pulse one cycle later), is never granted, and leaves the status byte unchanged.
- R4: Block-protect value bp (status bits 3:2) guards addresses as follows: 0 guards none, 1 guards the top quarter (addr >= 3/4 of depth), 2 guards the top half, and 3 guards every address. A request to a guarded address is denied and starts no cycle. Any other request is granted at the rising edge of chip select.
- R5: With `wp_n` high, a permitted status write is granted (`wr_grant_o` and `wr_grant_sr_o`, one cycle after chip select rises). It loads bp from data bits 3:2 and the arming bit from data bit 7.
- R6: With `wp_n` low and the arming bit (status bit 7) at 1, a status write request is denied and the status byte is unchanged.
- R7: With the arming bit at 0, `wp_n` low has no effect on status writes.
- R8: If the pin is armed and `wp_n` falls while a status write is pending, the write is cancelled. A deny pulse follows and no grant is given. This also holds when the fall is seen in the same cycle as the rise of chip select.
- R9: A change of `wp_n` after a status write has been granted does not alter that write or its result.
- R10: After a grant, the busy bit (status bit 0) is high for exactly WR_CYCLES cycles. The write-enable latch reads 0 once busy falls.
- R11: Status bits 6:4 always read 0.
- R12: While busy is high, write requests are denied, and `cmd_wren` and `cmd_wrdi` are ignored.
- R13: The `wp_n` pin never blocks array writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; its rising edge commits a pending write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| cmd_wren | input | 1 | Pulse: set write-enable latch |
| cmd_wrdi | input | 1 | Pulse: clear write-enable latch |
| cmd_wrsr | input | 1 | Pulse: status write request carrying `sr_wdata` |
| cmd_array_wr | input | 1 | Pulse: array write request at `wr_addr` |
| sr_wdata | input | 8 | New status value (bit 7 arming bit, bits 3:2 block protect) |
| wr_addr | input | ADDR_W | Target address of an array write |
| status_o | output | 8 | Status byte: bit 7 arm, bits 3:2 bp, bit 1 latch, bit 0 busy |
| wr_grant_o | output | 1 | One-cycle pulse: internal write cycle started |
| wr_grant_sr_o | output | 1 | With the grant: the granted write targets the status register |
| wr_deny_o | output | 1 | One-cycle pulse: request refused or pending write cancelled |

## Verification
Two events can land on the same clock edge: the commit at the rising edge of chip select, and the cancel caused by the armed protect pin falling. The bench forces this by driving `cs_n` high and `wp_n` low in the same cycle while a status write is pending. It expects a deny pulse, no grant and an unchanged status byte, because the cancel wins. It also drops `wp_n` one cycle after a grant and expects the new status value and the full busy length, showing that a cycle already under way is immune to the pin.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    BP_NONE    = 2'd0,
    BP_QUARTER = 2'd1,
    BP_HALF    = 2'd2,
    BP_ALL     = 2'd3
  } bp_level_e;

  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_BP_LO = 2;
  localparam int unsigned SB_BP_HI = 3;
  localparam int unsigned SB_ARM  = 7;

  function automatic logic [7:0] pack_status(input logic arm, input logic [1:0] bp,
                                             input logic wel, input logic busy);
    return {arm, 3'b000, bp, wel, busy};
  endfunction

  function automatic logic [1:0] bp_of(input logic [7:0] sr);
    return sr[SB_BP_HI:SB_BP_LO];
  endfunction

endpackage

// File: rtl/wpc_protect.sv
module wpc_protect #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              guarded_o
);
  import wpc_pkg::*;

  localparam int unsigned TOP = ADDR_W - 1;

  logic in_top_half;
  logic in_top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_top_half    = addr_i[TOP];
      assign in_top_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign in_top_half    = addr_i[TOP];
      assign in_top_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (bp_level_e'(bp_i))
      BP_NONE:    guarded_o = 1'b0;
      BP_QUARTER: guarded_o = in_top_quarter;
      BP_HALF:    guarded_o = in_top_half;
      default:    guarded_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/wpc_timer.sv
module wpc_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/wpc_wel.sv
module wpc_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/wpc_top.sv
module wpc_top #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned WR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_array_wr,
  input  logic [7:0]        sr_wdata,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_o,
  output logic              wr_grant_o,
  output logic              wr_grant_sr_o,
  output logic              wr_deny_o
);
  import wpc_pkg::*;

  logic       cs_q;
  logic       arm_q;
  logic [1:0] bp_q;
  logic       pend_v;
  logic       pend_sr;
  logic [7:0] pend_data;

  logic busy;
  logic cyc_done;
  logic wel;
  logic guarded;

  // named internal events
  logic cs_rise;
  logic pin_armed;
  logic sr_ok;
  logic arr_ok;
  logic deny_req;
  logic sr_cancel;
  logic start_wr;

  wpc_protect #(.ADDR_W(ADDR_W)) u_protect (
    .bp_i      (bp_q),
    .addr_i    (wr_addr),
    .guarded_o (guarded)
  );

  wpc_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_wr),
    .busy_o  (busy),
    .done_o  (cyc_done)
  );

  wpc_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cmd_wren && !busy),
    .clr_i ((cmd_wrdi && !busy) || cyc_done),
    .wel_o (wel)
  );

  assign cs_rise   = cs_n && !cs_q;
  assign pin_armed = arm_q && !wp_n;
  assign sr_ok     = cmd_wrsr && !busy && wel && !pin_armed && !pend_v;
  assign arr_ok    = cmd_array_wr && !cmd_wrsr && !busy && wel && !guarded && !pend_v;
  assign deny_req  = (cmd_wrsr && !sr_ok) || (cmd_array_wr && !arr_ok);
  assign sr_cancel = pend_v && pend_sr && pin_armed;
  assign start_wr  = cs_rise && pend_v && !sr_cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_sr   <= 1'b0;
      pend_data <= '0;
    end else if (cs_rise || sr_cancel) begin
      pend_v  <= 1'b0;
      pend_sr <= 1'b0;
    end else if (sr_ok) begin
      pend_v    <= 1'b1;
      pend_sr   <= 1'b1;
      pend_data <= sr_wdata;
    end else if (arr_ok) begin
      pend_v  <= 1'b1;
      pend_sr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      bp_q  <= 2'b00;
    end else if (start_wr && pend_sr) begin
      arm_q <= pend_data[SB_ARM];
      bp_q  <= bp_of(pend_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_grant_o    <= 1'b0;
      wr_grant_sr_o <= 1'b0;
      wr_deny_o     <= 1'b0;
    end else begin
      wr_grant_o    <= start_wr;
      wr_grant_sr_o <= start_wr && pend_sr;
      wr_deny_o     <= deny_req || sr_cancel;
    end
  end

  assign status_o = pack_status(arm_q, bp_q, wel, busy);

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_o,
  input logic       wr_grant_o,
  input logic       wr_deny_o,
  input logic       sr_cancel,
  input logic       start_wr
);

  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant_o |-> status_o[1]);

  a_r10_grant_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (wr_grant_o && status_o[0]));

  a_r10_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  a_r12_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant_o |-> !$past(status_o[0]));

  a_r9_status_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && $past(status_o[0])) |-> $stable({status_o[7], status_o[3:2]}));

  a_r8_cancel_denies: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cancel |=> (wr_deny_o && !wr_grant_o));

endmodule

bind wpc_top wpc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_o   (status_o),
  .wr_grant_o (wr_grant_o),
  .wr_deny_o  (wr_deny_o),
  .sr_cancel  (sr_cancel),
  .start_wr   (start_wr)
);

// File: tb/wpc_top_tb_top.sv
`timescale 1ns/1ps
module wpc_top_tb_top;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned WR_CYCLES = 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_array_wr = 0;
  logic [7:0] sr_wdata = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] status_o;
  logic wr_grant_o, wr_grant_sr_o, wr_deny_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wpc_top #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_array_wr(cmd_array_wr), .sr_wdata(sr_wdata), .wr_addr(wr_addr),
    .status_o(status_o), .wr_grant_o(wr_grant_o),
    .wr_grant_sr_o(wr_grant_sr_o), .wr_deny_o(wr_deny_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wren_p();
    cmd_wren = 1; tick(); cmd_wren = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status_o[0] && n < 100) begin n++; tick(); end
  endtask

  task automatic write_op(input bit is_sr, input logic [7:0] d, input int a,
                          output bit den, output bit gnt, output int bcnt);
    cs_n = 0; tick();
    if (is_sr) cmd_wrsr = 1; else cmd_array_wr = 1;
    sr_wdata = d; wr_addr = ADDR_W'(a);
    tick();
    den = wr_deny_o; cmd_wrsr = 0; cmd_array_wr = 0;
    tick();
    cs_n = 1; tick();
    gnt = wr_grant_o;
    wait_idle(bcnt);
  endtask

  task automatic set_status(input logic [7:0] d);
    bit den, gnt; int n;
    wren_p();
    write_op(1, d, 0, den, gnt, n);
  endtask

  function automatic bit exp_guard(input int bp, input int a);
    case (bp)
      0: return 0;
      1: return a >= (DEPTH * 3) / 4;
      2: return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 status", status_o, 0);
    chk("R1 grant", wr_grant_o, 0);
    chk("R1 deny", wr_deny_o, 0);
  endtask

  task automatic t_wel();
    wren_p();
    chk("R2 wren sets", status_o[1], 1);
    cmd_wrdi = 1; tick(); cmd_wrdi = 0;
    chk("R2 wrdi clears", status_o[1], 0);
    cmd_wren = 1; cmd_wrdi = 1; tick(); cmd_wren = 0; cmd_wrdi = 0;
    chk("R2 both clear", status_o[1], 0);
  endtask

  task automatic t_no_wel();
    bit den, gnt; int n;
    write_op(0, 0, 5, den, gnt, n);
    chk("R3 array deny", den, 1);
    chk("R3 array no grant", gnt, 0);
    write_op(1, 8'h8C, 0, den, gnt, n);
    chk("R3 sr deny", den, 1);
    chk("R3 sr no grant", gnt, 0);
    chk("R3 status kept", status_o, 0);
  endtask

  task automatic t_sr_write();
    bit den, gnt; int n;
    wren_p();
    write_op(1, 8'h7C, 0, den, gnt, n);
    chk("R5 sr grant", gnt, 1);
    chk("R5 sr not denied", den, 0);
    chk("R10 busy length", n, WR_CYCLES);
    chk("R11 unused zero and bp loaded", status_o, 8'h0C);
    chk("R10 wel cleared", status_o[1], 0);
    set_status(8'h00);
    chk("R5 bp back to 0", status_o, 0);
  endtask

  task automatic t_bp();
    int addrs[6] = '{0, 511, 512, 767, 768, 1023};
    for (int bp = 0; bp < 4; bp++) begin
      set_status(8'(bp << 2));
      for (int i = 0; i < 6; i++) begin
        bit den, gnt; int n;
        wren_p();
        write_op(0, 0, addrs[i], den, gnt, n);
        chk($sformatf("R4 bp%0d addr%0d deny", bp, addrs[i]), den, exp_guard(bp, addrs[i]));
        chk($sformatf("R4 bp%0d addr%0d grant", bp, addrs[i]), gnt, !exp_guard(bp, addrs[i]));
        cmd_wrdi = 1; tick(); cmd_wrdi = 0;
      end
    end
    set_status(8'h00);
  endtask

  task automatic t_wp_armed();
    bit den, gnt; int n;
    set_status(8'h80);
    chk("R11 arm bit7", status_o, 8'h80);
    wp_n = 0;
    wren_p();
    write_op(1, 8'h00, 0, den, gnt, n);
    chk("R6 sr denied", den, 1);
    chk("R6 no grant", gnt, 0);
    chk("R6 status kept", status_o, 8'h82);
    write_op(0, 0, 3, den, gnt, n);
    chk("R13 array grant with wp low", gnt, 1);
    wp_n = 1;
    set_status(8'h00);
  endtask

  task automatic t_unarmed();
    bit den, gnt; int n;
    wp_n = 0;
    set_status(8'h08);
    chk("R7 sr write with wp low", status_o, 8'h08);
    set_status(8'h00);
    chk("R7 sr write back", status_o, 8'h00);
    wp_n = 1;
  endtask

  task automatic t_cancel();
    set_status(8'h80);
    wren_p();
    cs_n = 0; tick();
    cmd_wrsr = 1; sr_wdata = 8'h88; tick();
    chk("R8 accepted first", wr_deny_o, 0);
    cmd_wrsr = 0; wp_n = 0; tick();
    chk("R8 cancel deny", wr_deny_o, 1);
    cs_n = 1; tick();
    chk("R8 no grant", wr_grant_o, 0);
    chk("R8 status kept", status_o, 8'h82);
    wp_n = 1; tick();
    // same-cycle: pin fall with chip select rise
    cs_n = 0; tick();
    cmd_wrsr = 1; sr_wdata = 8'h88; tick();
    cmd_wrsr = 0; cs_n = 1; wp_n = 0; tick();
    chk("R8 same-cycle no grant", wr_grant_o, 0);
    chk("R8 same-cycle deny", wr_deny_o, 1);
    chk("R8 same-cycle status", status_o, 8'h82);
    wp_n = 1; tick();
  endtask

  task automatic t_after_start();
    int n;
    cs_n = 0; tick();
    cmd_wrsr = 1; sr_wdata = 8'h84; tick();
    cmd_wrsr = 0; cs_n = 1; tick();
    chk("R9 grant", wr_grant_o, 1);
    chk("R5 grant is status", wr_grant_sr_o, 1);
    wp_n = 0;
    wait_idle(n);
    chk("R9 busy unaffected", n, WR_CYCLES);
    chk("R9 status applied", status_o, 8'h84);
    wp_n = 1;
    set_status(8'h00);
  endtask

  task automatic t_busy();
    int n;
    wren_p();
    cs_n = 0; tick();
    cmd_array_wr = 1; wr_addr = 7; tick();
    cmd_array_wr = 0; cs_n = 1; tick();
    chk("R12 grant", wr_grant_o, 1);
    cmd_wrdi = 1; tick(); cmd_wrdi = 0;
    chk("R12 wrdi ignored", status_o[1], 1);
    cs_n = 0; cmd_array_wr = 1; tick(); cmd_array_wr = 0;
    chk("R12 deny while busy", wr_deny_o, 1);
    cmd_wren = 1; tick(); cmd_wren = 0; cs_n = 1;
    wait_idle(n);
    tick();
    chk("R12 wren ignored", status_o[1], 0);
    chk("R12 no late grant", wr_grant_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_wel();
    t_no_wel();
    t_sr_write();
    t_bp();
    t_wp_armed();
    t_unarmed();
    t_cancel();
    t_after_start();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule